// File: doc/BRIEF.md
# Block Sequence Source Control Register Bank

This block is the software-facing register bank for a periodic block-framing source. A processor reaches it through a word-addressed write/read bus. Toward the framing source it drives the enable request, the start-at-pulse request, the number of blocks between sync marks, and a 64-bit starting sequence number together with a one-cycle load strobe. From the source it receives the on-status, the sync and start-of-packet markers, and the live 64-bit sequence count.

Software stages the lower word of the starting number first and then writes the upper word. The full 64-bit value and the load strobe reach the source only on that upper write, so the source never sees a half-updated number. The running count is latched on each block that carries the sync mark. Reading the lower captured word also freezes the upper captured word into a shadow register, so a read of the lower word followed by a read of the upper word always gives a matching pair.

The mode register holds one of three requests: off, start now, or start at the next pulse. Reading it back reports the request only while the source says it is running. Everything runs on one clock.

Top module: `bsn_ctrl_regs`

## Requirements
- R1: After reset, `src_en_o`, `src_en_pps_o`, `init_seq_load_o` and `rvalid_o` are 0. `init_seq_o` and `rdata_o` are 0, the captured sequence number is 0, and `blk_per_sync_o` equals the parameter `DEF_BLK_PER_SYNC`.
- R2: A write to word address 0 sets the mode from data bits 1:0. Value 1 gives `src_en_o`=1 and `src_en_pps_o`=0. Value 3 gives 1 and 1. Any value with bit 0 clear gives 0 and 0. Bits above 1 are ignored. The outputs change on the clock edge that accepts the write.
- R3: A read of address 0 returns the stored mode in bits 1:0 while `src_on_i` is 1, and returns 0 while it is 0. Bits above 1 always read 0.
- R4: Address 1 is the blocks-per-sync register. A write stores the full 32-bit word, drives it on `blk_per_sync_o`, and reads back unchanged.
- R5: A write to address 2 only stages the lower word of the starting number. `init_seq_o` is unchanged and `init_seq_load_o` stays 0.
- R6: A write to address 3 puts {written word, staged lower word} on `init_seq_o` and pulses `init_seq_load_o` high for exactly one cycle. The staged lower word is kept for later upper writes.
- R7: The live count `seq_i` is captured only on a cycle where `sync_i` and `sop_i` are both 1. A cycle with `sync_i` alone captures nothing.
- R8: A read of address 2 returns bits 31:0 of the captured number. Repeated reads between two captures give the same value, whatever `seq_i` does.
- R9: A read of address 2 copies bits 63:32 of the captured number into a shadow. A read of address 3 returns that shadow, even if a new capture has happened since.
- R10: Read data and `rvalid_o` appear one cycle after `rd_en_i`. When no read was requested the cycle before, `rvalid_o` is 0 and `rdata_o` is 0.
- R11: Addresses 4 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write request |
| rd_en_i | input | 1 | Bus read request |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | WORD_W | Write data |
| rdata_o | output | WORD_W | Read data, one cycle after the request |
| rvalid_o | output | 1 | Read data valid |
| src_en_o | output | 1 | Enable request to the source |
| src_en_pps_o | output | 1 | Start-at-next-pulse request |
| blk_per_sync_o | output | WORD_W | Blocks between sync marks |
| init_seq_o | output | 2*WORD_W | Starting sequence number |
| init_seq_load_o | output | 1 | One-cycle strobe when `init_seq_o` is updated |
| src_on_i | input | 1 | Source reports it is running |
| sync_i | input | 1 | Source sync marker |
| sop_i | input | 1 | Source start-of-packet marker |
| seq_i | input | 2*WORD_W | Live sequence count |

## Verification
Every register update, including the mode outputs, `blk_per_sync_o`, `init_seq_o` and its strobe, and the capture, takes effect on the same clock edge that accepts the request. The bench drives each request on a falling edge and checks the result at the next falling edge, after exactly one register stage. Read data has the same single-stage delay, so the value is sampled at the falling edge right after the read cycle, when `rvalid_o` is first high. The strobe is checked again one cycle later to show it has dropped. A capture is checked by reading after the marker cycle ends, once `seq_i` has already moved on.

// File: rtl/bsn_ctrl_pkg.sv
package bsn_ctrl_pkg;
  localparam int unsigned ADR_MODE = 0;
  localparam int unsigned ADR_BPS  = 1;
  localparam int unsigned ADR_SEQ_LO = 2;
  localparam int unsigned ADR_SEQ_HI = 3;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_NOW = 2'b01,
    MODE_PPS = 2'b11
  } mode_e;
endpackage

// File: rtl/bsn_ctrl_mode.sv
module bsn_ctrl_mode
  import bsn_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       src_on_i,
  output logic       en_o,
  output logic       pps_o,
  output logic [1:0] rd_val_o
);
  mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else if (wr_i) begin
      // bit 0 gates the whole request; bit 1 alone means off
      if (!wdata_i[0])     mode_q <= MODE_OFF;
      else if (wdata_i[1]) mode_q <= MODE_PPS;
      else                 mode_q <= MODE_NOW;
    end
  end

  assign en_o     = mode_q[0];
  assign pps_o    = mode_q[1];
  assign rd_val_o = src_on_i ? mode_q : MODE_OFF;
endmodule

// File: rtl/bsn_ctrl_init.sv
module bsn_ctrl_init #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned SEQ_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [SEQ_W-1:0]  seq_o,
  output logic              load_o
);
  logic [WORD_W-1:0] stage_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_lo_q <= '0;
      seq_o      <= '0;
      load_o     <= 1'b0;
    end else begin
      load_o <= wr_hi_i;
      if (wr_lo_i) stage_lo_q <= wdata_i;
      if (wr_hi_i) seq_o <= {wdata_i, stage_lo_q};
    end
  end
endmodule

// File: rtl/bsn_ctrl_capture.sv
module bsn_ctrl_capture #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned SEQ_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              sop_i,
  input  logic [SEQ_W-1:0]  seq_i,
  input  logic              rd_lo_i,
  output logic [WORD_W-1:0] lo_o,
  output logic [WORD_W-1:0] hi_o
);
  logic [SEQ_W-1:0]  cap_q;
  logic [WORD_W-1:0] shadow_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q       <= '0;
      shadow_hi_q <= '0;
    end else begin
      if (sync_i && sop_i) cap_q <= seq_i;
      // freeze upper word against the value the lower read sees
      if (rd_lo_i) shadow_hi_q <= cap_q[SEQ_W-1:WORD_W];
    end
  end

  assign lo_o = cap_q[WORD_W-1:0];
  assign hi_o = shadow_hi_q;
endmodule

// File: rtl/bsn_ctrl_regs.sv
module bsn_ctrl_regs
  import bsn_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEF_BLK_PER_SYNC = 8,
  localparam int unsigned SEQ_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              src_en_o,
  output logic              src_en_pps_o,
  output logic [WORD_W-1:0] blk_per_sync_o,
  output logic [SEQ_W-1:0]  init_seq_o,
  output logic              init_seq_load_o,
  input  logic              src_on_i,
  input  logic              sync_i,
  input  logic              sop_i,
  input  logic [SEQ_W-1:0]  seq_i
);
  logic sel_mode, sel_bps, sel_lo, sel_hi;
  logic [1:0]        mode_rd;
  logic [WORD_W-1:0] cap_lo, cap_hi;
  logic [WORD_W-1:0] rd_mux;

  assign sel_mode = (addr_i == ADDR_W'(ADR_MODE));
  assign sel_bps  = (addr_i == ADDR_W'(ADR_BPS));
  assign sel_lo   = (addr_i == ADDR_W'(ADR_SEQ_LO));
  assign sel_hi   = (addr_i == ADDR_W'(ADR_SEQ_HI));

  bsn_ctrl_mode u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i && sel_mode),
    .wdata_i  (wdata_i[1:0]),
    .src_on_i (src_on_i),
    .en_o     (src_en_o),
    .pps_o    (src_en_pps_o),
    .rd_val_o (mode_rd)
  );

  bsn_ctrl_init #(.WORD_W(WORD_W)) u_init (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_en_i && sel_lo),
    .wr_hi_i (wr_en_i && sel_hi),
    .wdata_i (wdata_i),
    .seq_o   (init_seq_o),
    .load_o  (init_seq_load_o)
  );

  bsn_ctrl_capture #(.WORD_W(WORD_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .sop_i   (sop_i),
    .seq_i   (seq_i),
    .rd_lo_i (rd_en_i && sel_lo),
    .lo_o    (cap_lo),
    .hi_o    (cap_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blk_per_sync_o <= WORD_W'(DEF_BLK_PER_SYNC);
    else if (wr_en_i && sel_bps) blk_per_sync_o <= wdata_i;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_mode)    rd_mux = {{(WORD_W-2){1'b0}}, mode_rd};
    else if (sel_bps) rd_mux = blk_per_sync_o;
    else if (sel_lo)  rd_mux = cap_lo;
    else if (sel_hi)  rd_mux = cap_hi;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      rdata_o  <= rd_en_i ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/bsn_ctrl_regs_chk.sv
module bsn_ctrl_regs_chk #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned SEQ_W = 2 * WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              src_en_o,
  input logic              src_en_pps_o,
  input logic [SEQ_W-1:0]  init_seq_o,
  input logic              init_seq_load_o,
  input logic              src_on_i
);
  // R10: read data one cycle after request, quiet otherwise
  assert_rvalid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rvalid_o && rdata_o == '0));

  // R2: mode outputs follow the written encoding
  assert_mode_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(0)) |=>
      (src_en_o == $past(wdata_i[0]) &&
       src_en_pps_o == ($past(wdata_i[0]) && $past(wdata_i[1]))));
  assert_pps_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_en_pps_o |-> src_en_o);

  // R3: mode reads zero while the source is off
  assert_mode_rd_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(0) && !src_on_i) |=> (rdata_o == '0));

  // R5: staging the lower word leaves the output alone
  assert_stage_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(2)) |=> ($stable(init_seq_o) && !init_seq_load_o));

  // R6: upper write commits and strobes
  assert_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(3)) |=>
      (init_seq_load_o && init_seq_o[SEQ_W-1:WORD_W] == $past(wdata_i)));
  assert_no_stray_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_W'(3)) |=> (!init_seq_load_o && $stable(init_seq_o)));
endmodule

bind bsn_ctrl_regs bsn_ctrl_regs_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .rd_en_i         (rd_en_i),
  .addr_i          (addr_i),
  .wdata_i         (wdata_i),
  .rdata_o         (rdata_o),
  .rvalid_o        (rvalid_o),
  .src_en_o        (src_en_o),
  .src_en_pps_o    (src_en_pps_o),
  .init_seq_o      (init_seq_o),
  .init_seq_load_o (init_seq_load_o),
  .src_on_i        (src_on_i)
);

// File: tb/bsn_ctrl_regs_bench.sv
`timescale 1ns/1ps
module bsn_ctrl_regs_bench;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned DEF_BPS = 8;
  localparam int unsigned SEQ_W = 2 * WORD_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [WORD_W-1:0] wdata = '0;
  logic [WORD_W-1:0] rdata;
  logic              rvalid, en, en_pps, load;
  logic [WORD_W-1:0] bps;
  logic [SEQ_W-1:0]  init_seq;
  logic              src_on = 1'b0, sync = 1'b0, sop = 1'b0;
  logic [SEQ_W-1:0]  seq = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bsn_ctrl_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DEF_BLK_PER_SYNC(DEF_BPS)) u_bsn_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .src_en_o(en),
    .src_en_pps_o(en_pps), .blk_per_sync_o(bps), .init_seq_o(init_seq),
    .init_seq_load_o(load), .src_on_i(src_on), .sync_i(sync), .sop_i(sop), .seq_i(seq)
  );

  typedef struct packed {
    logic [2:0]  waddr;
    logic [31:0] wdata;
    logic [2:0]  raddr;
    logic        on;
    logic [31:0] exp;
    logic        en;
    logic        pps;
  } vec_t;

  localparam vec_t TABLE [10] = '{
    '{3'd0, 32'h1,        3'd0, 1'b1, 32'h1,        1'b1, 1'b0},
    '{3'd0, 32'h3,        3'd0, 1'b1, 32'h3,        1'b1, 1'b1},
    '{3'd0, 32'h3,        3'd0, 1'b0, 32'h0,        1'b1, 1'b1},
    '{3'd0, 32'h2,        3'd0, 1'b1, 32'h0,        1'b0, 1'b0},
    '{3'd0, 32'h0,        3'd0, 1'b1, 32'h0,        1'b0, 1'b0},
    '{3'd1, 32'h10,       3'd1, 1'b0, 32'h10,       1'b0, 1'b0},
    '{3'd1, 32'hFFFFFFFF, 3'd1, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0},
    '{3'd5, 32'h1234,     3'd5, 1'b0, 32'h0,        1'b0, 1'b0},
    '{3'd7, 32'h55,       3'd1, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0},
    '{3'd0, 32'hFFFFFF07, 3'd0, 1'b1, 32'h3,        1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check("R10 rvalid", 64'(rvalid), 64'd1);
    d = rdata;
  endtask

  task automatic mark(input logic s, input logic p, input logic [SEQ_W-1:0] v);
    @(negedge clk);
    sync = s; sop = p; seq = v;
    @(negedge clk);
    sync = 1'b0; sop = 1'b0; seq = v + 64'd1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [WORD_W-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 en", 64'(en), 64'd0);
    check("R1 pps", 64'(en_pps), 64'd0);
    check("R1 init_seq", init_seq, 64'd0);
    check("R1 load", 64'(load), 64'd0);
    check("R1 bps", 64'(bps), 64'(DEF_BPS));
    check("R1 rvalid", 64'(rvalid), 64'd0);
    check("R1 rdata", 64'(rdata), 64'd0);
    bus_rd(3'd2, d);
    check("R1 captured lo", 64'(d), 64'd0);

    // table: write, check outputs, read back (R2 R3 R4 R11)
    foreach (TABLE[i]) begin
      src_on = TABLE[i].on;
      bus_wr(TABLE[i].waddr, TABLE[i].wdata);
      check($sformatf("R2 en vec%0d", i), 64'(en), 64'(TABLE[i].en));
      check($sformatf("R2 pps vec%0d", i), 64'(en_pps), 64'(TABLE[i].pps));
      bus_rd(TABLE[i].raddr, d);
      check($sformatf("R3/R4/R11 rdata vec%0d", i), 64'(d), 64'(TABLE[i].exp));
    end
    check("R4 bps out", 64'(bps), 64'hFFFFFFFF);

    // R10: quiet bus one cycle after read ends
    @(negedge clk);
    check("R10 rvalid idle", 64'(rvalid), 64'd0);
    check("R10 rdata idle", 64'(rdata), 64'd0);

    // R5 stage only
    bus_wr(3'd2, 32'hAAAA5555);
    check("R5 init unchanged", init_seq, 64'd0);
    check("R5 no load", 64'(load), 64'd0);
    // R6 commit
    bus_wr(3'd3, 32'h00000012);
    check("R6 init value", init_seq, 64'h00000012_AAAA5555);
    check("R6 load high", 64'(load), 64'd1);
    @(negedge clk);
    check("R6 load one cycle", 64'(load), 64'd0);
    bus_wr(3'd3, 32'h00000099);
    check("R6 staged kept", init_seq, 64'h00000099_AAAA5555);

    // R7 sync without sop does not capture
    mark(1'b1, 1'b0, 64'h1111_2222_3333_4444);
    bus_rd(3'd2, d);
    check("R7 no capture", 64'(d), 64'd0);
    // R7/R8 capture with sync and sop
    mark(1'b1, 1'b1, 64'h1111_2222_3333_4444);
    bus_rd(3'd2, d);
    check("R7 capture lo", 64'(d), 64'h33334444);
    bus_rd(3'd3, d);
    check("R9 capture hi", 64'(d), 64'h11112222);
    seq = 64'hDEAD_BEEF_0000_0001;
    bus_rd(3'd2, d);
    check("R8 repeat read lo", 64'(d), 64'h33334444);

    // R9 shadow survives a new capture
    mark(1'b1, 1'b1, 64'h5555_6666_7777_8888);
    bus_rd(3'd3, d);
    check("R9 shadow held", 64'(d), 64'h11112222);
    bus_rd(3'd2, d);
    check("R8 new lo", 64'(d), 64'h77778888);
    bus_rd(3'd3, d);
    check("R9 new hi", 64'(d), 64'h55556666);

    done = 1;
    summary();
    $finish;
  end
endmodule